// File: doc/BRIEF.md
# System Option Register with Time-Limited Write Protection

This block is an 8-bit configuration register on a simple address/data bus with separate read and write strobes. It drives seven control outputs: converter power-up, converter clock select, IRQ edge mode, oscillator start-up delay, clock-monitor enable and a two-bit rate select. Three of these controls (power-up, clock select, clock-monitor enable) can be rewritten at any time. The other four are guarded by a one-shot window that opens when reset is released.

In normal mode the guarded bits take exactly one write. That write must land within the first 64 cycles after reset. The window closes at the first register write or when the 64 cycles run out, whichever comes first. After that, writes to the guarded bits are dropped and produce no error. When the special-mode strap is high, the guarded bits can be written at any time and as often as needed, and such writes do not use up the one-shot.

The asynchronous reset input goes through a two-stage synchronizer, so the internal reset ends on the second rising edge after `rst_n` goes high. The window cycle counter begins counting at the edge after that.

Top module: `sysopt_reg`

## Requirements
- R1: After reset the stored value is 0x10: osc_dly_en is 1, every other control output is 0, and a read returns 0x10.
- R2: The register answers only at bus offset 0x39. A write to any other offset changes nothing. bus_rdata is 0x00 unless bus_rd is high at offset 0x39.
- R3: Bits 7 (adc_pwr_up), 6 (adc_clk_sel) and 3 (clk_mon_en) take the written data on every write at 0x39, in either mode.
- R4: In normal mode only the first write at 0x39 that falls inside the window updates the guarded bits 5 (irq_edge_mode), 4 (osc_dly_en), 1 and 0 (rate_sel[1:0]). Any later write leaves them unchanged.
- R5: The window covers writes captured on rising edges 3 to 66 after rst_n deasserts, counting the first edge after deassertion as edge 1. From edge 67 on, normal-mode writes cannot change the guarded bits.
- R6: While special_mode is high, every write at 0x39 updates the guarded bits, whatever the cycle count. These writes do not close the normal-mode window.
- R7: Bit 2 is not implemented and always reads 0.
- R8: A read at 0x39 returns the current stored bits in their positions. irq_edge_mode = 0 selects level-sensitive IRQ and 1 selects edge-only IRQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | Test-mode strap; 1 lifts write protection |
| bus_addr | input | 6 | Register block offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| adc_pwr_up | output | 1 | Converter power-up (bit 7) |
| adc_clk_sel | output | 1 | Converter clock select (bit 6) |
| irq_edge_mode | output | 1 | 1 = edge-only IRQ (bit 5) |
| osc_dly_en | output | 1 | Oscillator start-up delay (bit 4) |
| clk_mon_en | output | 1 | Clock-monitor enable (bit 3) |
| rate_sel | output | 2 | Rate select (bits 1:0) |

## Verification
If the window counter or the one-shot flag holds the wrong value, the effect shows up on the guarded outputs and in read data on the cycle after the first normal-mode write that the design wrongly accepts or wrongly drops. For that reason the bench places writes on edge 66 and on edge 67 after reset, and it also issues a second write inside the window. A fault in the bit-enable mapping shows up on the very next read. The randomised sessions then compare every output pin after every write against a model that tracks only the edge index and the mode.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 6;
  localparam logic [AW-1:0] REG_OFS  = 6'h39;
  localparam logic [DW-1:0] RST_VAL  = 8'h10;
  localparam logic [DW-1:0] PROT_MSK = 8'h33;
  localparam logic [DW-1:0] FREE_MSK = 8'hC8;

  typedef struct packed {
    logic       adc_pwr;
    logic       adc_csel;
    logic       irq_edge;
    logic       osc_dly;
    logic       cmon;
    logic       rsvd;
    logic [1:0] rate;
  } opt_t;
endpackage

// File: rtl/sysopt_rst_sync.sv
module sysopt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/sysopt_window.sv
module sysopt_window #(
  parameter int unsigned WIN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic special,
  output logic win_open,
  output logic prot_ok
);
  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WIN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          used_q, used_d;
  logic          sat;

  always_comb begin
    sat    = (cnt_q == LIMIT);
    cnt_d  = sat ? cnt_q : cnt_q + 1'b1;
    used_d = used_q | (wr_hit & ~special);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      used_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      used_q <= used_d;
    end
  end

  assign win_open = ~used_q & ~sat;
  assign prot_ok  = special | win_open;
endmodule

// File: rtl/sysopt_bits.sv
module sysopt_bits #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] RST  = '0,
  parameter logic [DW-1:0] PROT = '0,
  parameter logic [DW-1:0] FREE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic          prot_ok,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (PROT[i] || FREE[i]) begin : g_store
      logic en, b_q, b_d;
      always_comb begin
        en  = PROT[i] ? (wr_hit & prot_ok) : wr_hit;
        b_d = en ? wdata[i] : b_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= RST[i];
        else        b_q <= b_d;
      end
      assign q[i] = b_q;
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
  import sysopt_pkg::*;
#(
  parameter int unsigned WIN       = 64,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          special_mode,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          adc_pwr_up,
  output logic          adc_clk_sel,
  output logic          irq_edge_mode,
  output logic          osc_dly_en,
  output logic          clk_mon_en,
  output logic [1:0]    rate_sel
);
  logic          rst_q_n;
  logic          sel, wr_hit, win_open, prot_ok;
  logic [DW-1:0] store;
  opt_t          opt;

  assign sel    = (bus_addr == REG_OFS);
  assign wr_hit = sel & bus_wr;

  sysopt_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  sysopt_window #(.WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_q_n), .wr_hit(wr_hit), .special(special_mode),
    .win_open(win_open), .prot_ok(prot_ok)
  );

  sysopt_bits #(.DW(DW), .RST(RST_VAL), .PROT(PROT_MSK), .FREE(FREE_MSK)) u_bits (
    .clk(clk), .rst_n(rst_q_n), .wr_hit(wr_hit), .prot_ok(prot_ok),
    .wdata(bus_wdata), .q(store)
  );

  assign opt           = opt_t'(store);
  assign bus_rdata     = (sel & bus_rd) ? store : '0;
  assign adc_pwr_up    = opt.adc_pwr;
  assign adc_clk_sel   = opt.adc_csel;
  assign irq_edge_mode = opt.irq_edge;
  assign osc_dly_en    = opt.osc_dly;
  assign clk_mon_en    = opt.cmon;
  assign rate_sel      = opt.rate;
endmodule

// File: rtl/sysopt_reg_chk.sv
module sysopt_reg_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic       wr_hit,
  input logic       win_open,
  input logic       special_mode,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       adc_pwr_up,
  input logic       adc_clk_sel,
  input logic       irq_edge_mode,
  input logic       osc_dly_en,
  input logic       clk_mon_en,
  input logic [1:0] rate_sel
);
  logic [3:0] guarded;
  logic [6:0] all_out;
  assign guarded = {irq_edge_mode, osc_dly_en, rate_sel};
  assign all_out = {adc_pwr_up, adc_clk_sel, irq_edge_mode, osc_dly_en, clk_mon_en, rate_sel};

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_hit |=> $stable(all_out));
  // R3
  free_bits_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_hit |=> (clk_mon_en == $past(bus_wdata[3])) && (adc_pwr_up == $past(bus_wdata[7]))
               && (adc_clk_sel == $past(bus_wdata[6])));
  // R4
  one_shot_close_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_hit && !special_mode) |=> !win_open);
  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_hit && !special_mode && !win_open) |=> $stable(guarded));
  // R5
  window_stays_shut_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !win_open |=> !win_open);
  // R6
  special_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_hit && special_mode) |=> (irq_edge_mode == $past(bus_wdata[5]))
                                  && (rate_sel == $past(bus_wdata[1:0])));
  // R7
  bit2_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_rdata[2] == 1'b0);
endmodule

bind sysopt_reg sysopt_reg_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .wr_hit(wr_hit), .win_open(win_open),
  .special_mode(special_mode), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .adc_pwr_up(adc_pwr_up), .adc_clk_sel(adc_clk_sel), .irq_edge_mode(irq_edge_mode),
  .osc_dly_en(osc_dly_en), .clk_mon_en(clk_mon_en), .rate_sel(rate_sel)
);

// File: tb/sim_sysopt_reg.sv
`timescale 1ns/1ps
module sim_sysopt_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       adc_pwr_up, adc_clk_sel, irq_edge_mode, osc_dly_en, clk_mon_en;
  logic [1:0] rate_sel;

  int checks = 0, fails = 0;
  int edge_cnt = 0;
  logic [7:0] exp_v;
  bit used;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edge_cnt <= 0; else edge_cnt <= edge_cnt + 1;

  sysopt_reg u0 (.*);

  function automatic bit in_window(int k);
    return (k >= 3) && (k <= 66);
  endfunction

  function automatic logic [7:0] pins();
    return {adc_pwr_up, adc_clk_sel, irq_edge_mode, osc_dly_en, clk_mon_en, 1'b0, rate_sel};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit spec);
    @(negedge clk);
    rst_n = 1'b0; special_mode = spec;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_v = 8'h10; used = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [5:0] a, logic [7:0] d);
    int k;
    k = edge_cnt + 1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (a == 6'h39 && k >= 3) begin
      exp_v[7] = d[7]; exp_v[6] = d[6]; exp_v[3] = d[3];
      if (special_mode || (!used && in_window(k))) begin
        exp_v[5] = d[5]; exp_v[4] = d[4]; exp_v[1:0] = d[1:0];
      end
      if (!special_mode) used = 1;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(string req);
    bus_addr = 6'h39; bus_rd = 1'b1;
    #1;
    chk(req, bus_rdata, exp_v);
    chk(req, pins(), exp_v);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    // R1 reset value
    do_reset(0);
    idle(3);
    read_chk("R1");
    // R2 read of another offset and no read strobe give zero
    bus_addr = 6'h38; bus_rd = 1'b1; #1; chk("R2", bus_rdata, 8'h00);
    bus_rd = 1'b0; bus_addr = 6'h39; #1; chk("R2", bus_rdata, 8'h00);
    @(negedge clk);
    // R2 write to other offset ignored (no window use)
    bus_write(6'h3A, 8'hFF);
    read_chk("R2");
    // R4 first write inside window, R8 edge-mode bit, R7 bit2 reads zero
    bus_write(6'h39, 8'h2F);
    read_chk("R4");
    chk("R8", {7'd0, irq_edge_mode}, 8'h01);
    chk("R7", {7'd0, bus_rdata[2]}, 8'h00);
    // R4 second write inside window: only free bits move
    bus_write(6'h39, 8'hD0);
    read_chk("R4");
    // R5 write on edge 66 accepted
    do_reset(0);
    idle(65);
    bus_write(6'h39, 8'h23);
    read_chk("R5");
    // R5 write on edge 67 rejected, R3 free bits still move
    do_reset(0);
    idle(66);
    bus_write(6'h39, 8'hEB);
    read_chk("R5");
    bus_write(6'h39, 8'h00);
    read_chk("R3");
    // R6 special mode: repeated late writes
    do_reset(1);
    idle(80);
    bus_write(6'h39, 8'h33);
    read_chk("R6");
    bus_write(6'h39, 8'h02);
    read_chk("R6");
    // random sessions
    for (int s = 0; s < 30; s++) begin
      do_reset($urandom_range(0, 3) == 0);
      for (int op = 0; op < 40; op++) begin
        case ($urandom_range(0, 3))
          0: idle($urandom_range(0, 6));
          1: bus_write(($urandom_range(0, 4) == 0) ? 6'($urandom) : 6'h39, 8'($urandom));
          default: read_chk(special_mode ? "R6" : "R4");
        endcase
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule